// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide unpacked form and turns it into a 32-bit IEEE-754 single-precision word. The unpacked value has a class code, a sign, a two's-complement unbiased exponent, a mantissa with its leading one at the top bit and two extra low bits, and a sticky bit. The sticky bit stands for any nonzero bits already lost below the mantissa. The block also takes a rounding mode and an underflow-trap enable. It is meant as the last stage of an arithmetic unit, after the operation has produced an exact or nearly exact unpacked result.

For finite nonzero values the block aligns the mantissa to the single-precision fraction. Any bits shifted past the two low rounding positions are folded into the sticky bit. The block then rounds and chooses between the normal, subnormal and overflow encodings. Infinity, zero and NaN bypass rounding. A NaN keeps the upper bits of its mantissa as its payload. The packed word and three exception flags (inexact, underflow, overflow) are registered. They appear one clock after the input strobe.

The numeric value of a finite input is `mant * 2^(exp - (MANT_W-1))`. Bit MANT_W-1 of the mantissa is the implied one.

Top module: `fp_single_packer`

## Requirements
- R1: After reset `out_valid`, `out_word` and all three flags are 0. Every `in_valid` cycle produces `out_valid` with its result exactly one clock later, and a cycle without `in_valid` gives `out_valid` 0 one clock later.
- R2: Class code 3 (NaN) packs as sign at bit 31, exponent field 0xFF, and fraction `in_mant[MANT_W-2 -: 23]`. No rounding is done and no flag is raised, whatever the mode, sticky or trap inputs.
- R3: Class code 2 (infinity) packs as sign, exponent 0xFF and fraction 0. Class code 0 (zero) packs as the sign bit alone. Neither raises a flag.
- R4: Rounding mode 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity. Inexact is raised exactly when any discarded bit or the sticky input is nonzero.
- R5: When exp+127 is 0 or less, the value is placed on the 2^-149 grid and rounded. If rounding carries it up to 2^-126, the result is the smallest normal, 0x00800000 with the sign, and no underflow is raised.
- R6: Otherwise a value on the subnormal path packs with exponent field 0 and the rounded fraction. Underflow is raised when the result is inexact or `in_uf_trap` is 1.
- R7: On the normal path a rounding carry out of the 24-bit significand increments the exponent and leaves the fraction at 0.
- R8: When the biased exponent after rounding is 255 or more, overflow and inexact are raised. The result is infinity in mode 0, in mode 2 for a positive sign and in mode 3 for a negative sign. Otherwise the result is the signed largest finite value, 0x7F7FFFFF with the sign.
- R9: Mantissa bits shifted below the two rounding positions act as sticky, including shifts wider than the whole mantissa.
- R10: A normal result packs as sign at bit 31, biased exponent at bits 30..23 and the low 23 bits of the rounded significand at bits 22..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_class | input | 2 | 0 zero, 1 finite number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, leading one at top bit |
| in_sticky | input | 1 | Nonzero bits already lost below the mantissa |
| in_rmode | input | 2 | Rounding mode |
| in_uf_trap | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
Every result, the word and all three flags, is registered once and is due on the first rising edge after the `in_valid` cycle. The bench drives each stimulus on a falling edge and compares outputs on the next falling edge, half a period after the capturing edge. The sweep walks all four modes, both signs, both sticky values, exponents across the subnormal, normal and overflow boundaries, and a set of mantissa patterns. Its expectation comes from an integer quotient-and-remainder model rather than from guard bits.

// File: rtl/fp_pack_pkg.sv
`timescale 1ns/1ps
package fp_pack_pkg;
  localparam int FRAC_W   = 23;
  localparam int EXPF_W   = 8;
  localparam int BIAS     = 127;
  localparam int EXP_ALL1 = 255;
  // 24 significand bits plus guard and round
  localparam int WIN_W    = FRAC_W + 3;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0, CLS_NUM = 2'd1, CLS_INF = 2'd2, CLS_NAN = 2'd3
  } val_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0, RM_ZERO = 2'd1, RM_UP = 2'd2, RM_DOWN = 2'd3
  } rnd_mode_e;

  // decide on an increment of the kept significand
  function automatic logic rnd_up(rnd_mode_e mode, logic sign, logic lsb,
                                  logic g, logic r, logic s);
    logic lost;
    lost = g | r | s;
    case (mode)
      RM_NEAR: return g & (r | s | lsb);
      RM_ZERO: return 1'b0;
      RM_UP:   return lost & ~sign;
      default: return lost & sign;
    endcase
  endfunction

  // overflow goes to infinity or to the largest finite magnitude
  function automatic logic ovf_to_inf(rnd_mode_e mode, logic sign);
    case (mode)
      RM_NEAR: return 1'b1;
      RM_ZERO: return 1'b0;
      RM_UP:   return ~sign;
      default: return sign;
    endcase
  endfunction
endpackage

// File: rtl/fp_pack_align.sv
`timescale 1ns/1ps
module fp_pack_align
  import fp_pack_pkg::*;
#(
  parameter int MANT_W = 28,
  parameter int EXP_W  = 10
) (
  input  logic [MANT_W-1:0]       mant,
  input  logic                    sticky_in,
  input  logic signed [EXP_W-1:0] exp_unb,
  output logic [WIN_W-1:0]        win,
  output logic                    sticky_out,
  output logic                    is_sub,
  output logic signed [EXP_W+1:0] bexp
);
  localparam int BX_W    = EXP_W + 2;
  localparam int BASE_SH = MANT_W - WIN_W;

  int                amt;
  logic [MANT_W-1:0] shifted;
  logic              lost;

  always_comb begin
    bexp   = {{2{exp_unb[EXP_W-1]}}, exp_unb} + BX_W'(BIAS);
    is_sub = (bexp <= 0);
    // subnormal: one more for the implied one, plus the exponent deficit
    amt    = is_sub ? (BASE_SH + 1 - int'(bexp)) : BASE_SH;
    if (amt >= MANT_W) begin
      shifted = '0;
      lost    = |mant;
    end else begin
      shifted = mant >> amt;
      lost    = |(mant & ~({MANT_W{1'b1}} << amt));
    end
    win        = shifted[WIN_W-1:0];
    sticky_out = sticky_in | lost;
  end
endmodule

// File: rtl/fp_pack_round.sv
`timescale 1ns/1ps
module fp_pack_round
  import fp_pack_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  input  logic             sticky,
  input  rnd_mode_e        mode,
  input  logic             sign,
  output logic [WIN_W-2:0] rounded,
  output logic             inexact
);
  logic [WIN_W-3:0] kept;
  logic             up;

  always_comb begin
    kept    = win[WIN_W-1:2];
    inexact = win[1] | win[0] | sticky;
    up      = rnd_up(mode, sign, kept[0], win[1], win[0], sticky);
    rounded = {1'b0, kept} + {{(WIN_W-2){1'b0}}, up};
  end
endmodule

// File: rtl/fp_single_packer.sv
`timescale 1ns/1ps
module fp_single_packer
  import fp_pack_pkg::*;
#(
  parameter int MANT_W = 28,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        in_rmode,
  input  logic              in_uf_trap,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              out_inexact,
  output logic              out_underflow,
  output logic              out_overflow
);
  localparam int BX_W = EXP_W + 2;

  val_class_e cls;
  rnd_mode_e  mode;
  assign cls  = val_class_e'(in_class);
  assign mode = rnd_mode_e'(in_rmode);

  // named internal events
  logic [WIN_W-1:0]       win;
  logic                   stk_all;
  logic                   is_sub;
  logic signed [BX_W-1:0] bexp;
  logic [WIN_W-2:0]       rounded;
  logic                   rnd_inexact;
  logic signed [BX_W-1:0] exp_final;
  logic                   ovf_hit;
  logic                   go_inf;

  fp_pack_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .mant(in_mant), .sticky_in(in_sticky), .exp_unb(in_exp),
    .win(win), .sticky_out(stk_all), .is_sub(is_sub), .bexp(bexp)
  );

  fp_pack_round u_round (
    .win(win), .sticky(stk_all), .mode(mode), .sign(in_sign),
    .rounded(rounded), .inexact(rnd_inexact)
  );

  assign exp_final = bexp + BX_W'(rounded[FRAC_W+1]);
  assign ovf_hit   = !is_sub && (exp_final >= BX_W'(EXP_ALL1));
  assign go_inf    = ovf_to_inf(mode, in_sign);

  logic [31:0] nxt_word;
  logic        nxt_nx, nxt_uf, nxt_of;

  always_comb begin
    nxt_word = '0;
    nxt_nx   = 1'b0;
    nxt_uf   = 1'b0;
    nxt_of   = 1'b0;
    case (cls)
      CLS_ZERO: nxt_word = {in_sign, 31'd0};
      CLS_INF:  nxt_word = {in_sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_NAN:  nxt_word = {in_sign, {EXPF_W{1'b1}}, in_mant[MANT_W-2 -: FRAC_W]};
      default: begin
        nxt_nx = rnd_inexact;
        if (is_sub) begin
          // a carry into bit 23 yields exponent field 1 directly
          nxt_word = {in_sign, {(EXPF_W-1){1'b0}}, rounded[FRAC_W], rounded[FRAC_W-1:0]};
          nxt_uf   = !rounded[FRAC_W] && (rnd_inexact || in_uf_trap);
        end else if (ovf_hit) begin
          nxt_of = 1'b1;
          nxt_nx = 1'b1;
          nxt_word = go_inf ? {in_sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                            : {in_sign, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
          nxt_word = {in_sign, exp_final[EXPF_W-1:0], rounded[FRAC_W-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_inexact   <= 1'b0;
      out_underflow <= 1'b0;
      out_overflow  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word      <= nxt_word;
        out_inexact   <= nxt_nx;
        out_underflow <= nxt_uf;
        out_overflow  <= nxt_of;
      end
    end
  end

  // R1: one-cycle strobe latency
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3 and R2: specials never raise a flag
  a_r3_special_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls != CLS_NUM) |=> (!out_inexact && !out_underflow && !out_overflow));
  // R8: overflow always comes with inexact and a top exponent
  a_r8_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_inexact && out_word[30:24] == 7'h7F));
  // R6: underflow only with a zero exponent field
  a_r6_uf_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> (out_word[30:23] == 8'h00 && !out_overflow));
endmodule

// File: tb/fp_single_packer_test.sv
`timescale 1ns/1ps
module fp_single_packer_test;
  localparam int MANT_W = 28;
  localparam int EXP_W  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        in_class = 2'd0;
  logic              in_sign = 1'b0;
  logic [EXP_W-1:0]  in_exp = '0;
  logic [MANT_W-1:0] in_mant = '0;
  logic              in_sticky = 1'b0;
  logic [1:0]        in_rmode = 2'd0;
  logic              in_uf_trap = 1'b0;
  logic              out_valid;
  logic [31:0]       out_word;
  logic              out_inexact, out_underflow, out_overflow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp_single_packer #(.MANT_W(MANT_W), .EXP_W(EXP_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .in_rmode(in_rmode), .in_uf_trap(in_uf_trap), .out_valid(out_valid),
    .out_word(out_word), .out_inexact(out_inexact), .out_underflow(out_underflow),
    .out_overflow(out_overflow)
  );

  // quotient/remainder reference model
  task automatic ref_pack(input int cls, input int sgn, input int e, input longint mant,
                          input int stk, input int md, input int trp,
                          output logic [31:0] w, output logic nx, output logic uf,
                          output logic of);
    longint kept, rem, half, r;
    int bexp, s, ex;
    logic above, tie, up, lost;
    logic [31:0] sb;
    sb = sgn ? 32'h8000_0000 : 32'h0;
    w = sb; nx = 0; uf = 0; of = 0;
    if (cls == 0) return;
    if (cls == 2) begin w = sb | 32'h7F80_0000; return; end
    if (cls == 3) begin w = sb | 32'h7F80_0000 | 32'((mant >> (MANT_W-24)) & 64'h7FFFFF); return; end
    bexp = e + 127;
    s = (bexp >= 1) ? (MANT_W - 24) : (MANT_W - 24 + 1 - bexp);
    if (s > 60) begin
      kept = 0; lost = 1; above = 0; tie = 0;
    end else begin
      kept = mant >> s;
      rem  = mant & ((64'd1 << s) - 1);
      half = 64'd1 << (s - 1);
      lost = (rem != 0) || (stk != 0);
      above = (rem > half) || (rem == half && stk != 0);
      tie   = (rem == half) && (stk == 0);
    end
    nx = lost;
    case (md)
      0: up = above || (tie && kept[0]);
      1: up = 0;
      2: up = lost && sgn == 0;
      default: up = lost && sgn == 1;
    endcase
    r = kept + (up ? 64'd1 : 64'd0);
    if (bexp >= 1) begin
      ex = bexp + int'(r >> 24);
      if (ex >= 255) begin
        of = 1; nx = 1;
        if (md == 0 || (md == 2 && sgn == 0) || (md == 3 && sgn == 1)) w = sb | 32'h7F80_0000;
        else w = sb | 32'h7F7F_FFFF;
      end else w = sb | (32'(ex) << 23) | 32'(r & 64'h7FFFFF);
    end else begin
      if (r >= 64'h800000) w = sb | 32'h0080_0000;
      else begin
        w = sb | 32'(r);
        uf = nx || (trp != 0);
      end
    end
  endtask

  task automatic apply(input int cls, input int sgn, input int e, input longint mant,
                       input int stk, input int md, input int trp);
    in_valid = 1'b1; in_class = 2'(cls); in_sign = 1'(sgn); in_exp = e[EXP_W-1:0];
    in_mant = mant[MANT_W-1:0]; in_sticky = 1'(stk); in_rmode = 2'(md); in_uf_trap = 1'(trp);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [31:0] w, input logic nx,
                            input logic uf, input logic of);
    checks++;
    if (out_valid !== 1'b1 || out_word !== w || out_inexact !== nx ||
        out_underflow !== uf || out_overflow !== of) begin
      errors++;
      $display("FAIL %s: got v=%b w=%h nx=%b uf=%b of=%b, expected v=1 w=%h nx=%b uf=%b of=%b",
               tag, out_valid, out_word, out_inexact, out_underflow, out_overflow, w, nx, uf, of);
    end
  endtask

  task automatic run_ref(input string tag, input int cls, input int sgn, input int e,
                         input longint mant, input int stk, input int md, input int trp);
    logic [31:0] w; logic nx, uf, of;
    ref_pack(cls, sgn, e, mant, stk, md, trp, w, nx, uf, of);
    apply(cls, sgn, e, mant, stk, md, trp);
    expect_out(tag, w, nx, uf, of);
  endtask

  function automatic longint pat(int i);
    case (i)
      0: return 64'h800_0000;
      1: return 64'hFFF_FFFF;
      2: return 64'h800_0008;
      3: return 64'h800_0018;
      4: return 64'hC00_0000;
      5: return 64'h800_000F;
      6: return 64'hAAA_AAAA;
      7: return 64'h800_0010;
      8: return 64'hFFF_FFF8;
      default: return 64'h999_9999;
    endcase
  endfunction

  bit finished = 0;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 0 || out_word !== 0 || out_inexact !== 0 || out_underflow !== 0 || out_overflow !== 0) begin
      errors++;
      $display("FAIL R1 reset: got v=%b w=%h, expected v=0 w=00000000", out_valid, out_word);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R10 plain 1.0
    apply(1, 0, 0, 64'h800_0000, 0, 0, 0);
    expect_out("R10 one", 32'h3F80_0000, 0, 0, 0);
    // R1 idle follows
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got v=%b, expected v=0", out_valid);
    end

    // R2 NaN payload, other inputs ignored
    apply(3, 1, 5, 64'hE12_3456, 1, 2, 1);
    expect_out("R2 nan payload", 32'hFFE1_2345, 0, 0, 0);
    apply(3, 0, -200, 64'hC00_000F, 0, 0, 0);
    expect_out("R2 nan quiet", 32'h7FC0_0000, 0, 0, 0);
    // R3 infinity and zero
    apply(2, 1, 0, 64'hFFF_FFFF, 1, 0, 1);
    expect_out("R3 neg inf", 32'hFF80_0000, 0, 0, 0);
    apply(0, 1, 0, 64'h0, 1, 3, 1);
    expect_out("R3 neg zero", 32'h8000_0000, 0, 0, 0);

    // R5 largest subnormal rounding up into smallest normal
    apply(1, 0, -127, 64'hFFF_FFFF, 0, 0, 1);
    expect_out("R5 sub carry", 32'h0080_0000, 1, 0, 0);
    // R6 same value truncated stays subnormal
    apply(1, 0, -127, 64'hFFF_FFFF, 0, 1, 0);
    expect_out("R6 sub trunc", 32'h007F_FFFF, 1, 1, 0);
    // R6 exact subnormal, trap on then off
    apply(1, 1, -130, 64'h800_0000, 0, 0, 1);
    expect_out("R6 exact trap", 32'h8008_0000, 0, 1, 0);
    apply(1, 1, -130, 64'h800_0000, 0, 0, 0);
    expect_out("R6 exact notrap", 32'h8008_0000, 0, 0, 0);

    // R7 rounding to 2.0
    apply(1, 0, 0, 64'hFFF_FFFF, 0, 0, 0);
    expect_out("R7 carry", 32'h4000_0000, 1, 0, 0);

    // R8 overflow in every mode, both signs
    apply(1, 0, 128, 64'h800_0000, 0, 0, 0); expect_out("R8 pos near", 32'h7F80_0000, 1, 0, 1);
    apply(1, 0, 128, 64'h800_0000, 0, 1, 0); expect_out("R8 pos zero", 32'h7F7F_FFFF, 1, 0, 1);
    apply(1, 0, 128, 64'h800_0000, 0, 2, 0); expect_out("R8 pos up",   32'h7F80_0000, 1, 0, 1);
    apply(1, 0, 128, 64'h800_0000, 0, 3, 0); expect_out("R8 pos down", 32'h7F7F_FFFF, 1, 0, 1);
    apply(1, 1, 128, 64'h800_0000, 0, 0, 0); expect_out("R8 neg near", 32'hFF80_0000, 1, 0, 1);
    apply(1, 1, 128, 64'h800_0000, 0, 1, 0); expect_out("R8 neg zero", 32'hFF7F_FFFF, 1, 0, 1);
    apply(1, 1, 128, 64'h800_0000, 0, 2, 0); expect_out("R8 neg up",   32'hFF7F_FFFF, 1, 0, 1);
    apply(1, 1, 128, 64'h800_0000, 0, 3, 0); expect_out("R8 neg down", 32'hFF80_0000, 1, 0, 1);
    apply(1, 0, 127, 64'hFFF_FFFF, 0, 0, 0); expect_out("R8 carry ovf", 32'h7F80_0000, 1, 0, 1);

    // R9 bits below guard act as sticky
    apply(1, 0, 0, 64'h800_0001, 0, 2, 0);
    expect_out("R9 fold normal", 32'h3F80_0001, 1, 0, 0);
    apply(1, 0, -400, 64'h800_0000, 0, 2, 0);
    expect_out("R9 deep up", 32'h0000_0001, 1, 1, 0);
    apply(1, 0, -400, 64'h800_0000, 0, 0, 0);
    expect_out("R9 deep near", 32'h0000_0000, 1, 1, 0);
    // R4 tie to even: kept even stays, odd goes up
    apply(1, 0, 0, 64'h800_0008, 0, 0, 0);
    expect_out("R4 tie even", 32'h3F80_0000, 1, 0, 0);
    apply(1, 0, 0, 64'h800_0018, 0, 0, 0);
    expect_out("R4 tie odd", 32'h3F80_0002, 1, 0, 0);

    // sweep: R4 R5 R6 R7 R8 R9 R10 against the reference model
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int band = 0; band < 3; band++)
          for (int k = 0; k < 41; k++) begin
            int e;
            if (band == 0) e = -160 + k;
            else if (band == 1) begin if (k > 10) break; e = 120 + k; end
            else begin if (k > 6) break; e = -3 + k; end
            for (int p = 0; p < 10; p++)
              for (int st = 0; st < 2; st++)
                run_ref((e + 127 <= 0) ? "R5/R6 sweep sub" :
                        (e + 127 >= 254) ? "R8 sweep ovf" : "R4/R7/R10 sweep norm",
                        1, sg, e, pat(p), st, md, p % 2);
          end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule